// File: doc/BRIEF.md
# Byte-Serial Status Packet Generator

The block reports a status word of up to 26 bits to a downstream collector as a short byte-serial packet on an 8-bit bus. When a packet is due, the generator freezes the status word together with a 6-bit sequence tag, raises a request and holds a header byte on the bus. The header carries the tag in its upper six bits and the two lowest status bits below them. Once the collector pulses the acknowledge input, the request drops and the rest of the status word follows, eight bits per clock, lowest slice first. The bus then returns to zero.

A one-byte control write selects the reporting mode and loads the sequence tag. In the off mode no packets are sent. In the single mode one packet goes out for each control write. In the auto mode a packet goes out when the mode is entered and again whenever the status word differs from the last value sent. The status width is a parameter, and it sets how many payload bytes follow the header.

Top module: `status_pkt_gen`

## Requirements
- R1: While reset is asserted and after it is released, rq is 0 and ad is 0 until a packet is started. The reset value of the mode is off.
- R2: While rq is 1, ad holds the header byte. The sequence tag is in ad[7:2] and status[1:0] is in ad[1:0].
- R3: rq stays 1 until start is sampled 1 at a rising clock edge. After that edge rq is 0.
- R4: On the clocks right after the acknowledge edge, ad carries status[9:2], then status[17:10], then status[25:18], one byte per clock. Status bit positions at or above PAYLOAD_BITS read as 0.
- R5: The number of payload bytes is ceil((PAYLOAD_BITS-2)/8), and PAYLOAD_BITS may be 3 to 26. After the last payload byte, ad is 0 on the next clock.
- R6: A control write (we=1) loads the mode from wd[7:6] and the tag from wd[5:0]. The mode codes are 01 single, 10 auto, 00 off and 11 off.
- R7: In the off mode rq never rises, whatever the status does.
- R8: In the single mode exactly one packet is sent per control write. A status change does not start another one.
- R9: In the auto mode a packet is sent on entry to the mode and whenever status differs from the value last sent. No packet is sent while status is unchanged.
- R10: Status and tag are captured in the clock in which rq rises. Later changes to status or to the tag do not alter the bytes of that packet.
- R11: Whenever rq is 0 and no payload byte is due, ad is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| we | input | 1 | Control write strobe |
| wd | input | 8 | Control write data: mode in [7:6], sequence tag in [5:0] |
| status | input | PAYLOAD_BITS | Status word to report |
| start | input | 1 | Acknowledge that the header byte was taken |
| rq | output | 1 | Request to send a packet; the header is on ad while high |
| ad | output | 8 | Byte-serial packet output |

## Verification
The case that is hardest to reach from the ports is a status change that arrives while a request is still waiting for its acknowledge. That packet must keep the captured value. In the auto mode, the new value must then produce a second packet straight after the first. The stimulus changes the status after rq rises, holds off the acknowledge for a few clocks and then acknowledges twice. The scoreboard expects the old bytes first and the new bytes second. Three instances with 7, 15 and 26 status bits run in lockstep, so the same stimulus covers one, two and three payload bytes and the zero padding of the top slice.

// File: rtl/status_pkt_pkg.sv
package status_pkt_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LOW_W    = 2;
  localparam int unsigned TAG_W    = BYTE_W - LOW_W;
  localparam int unsigned MAX_BITS = 26;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_SINGLE = 2'b01,
    MODE_AUTO   = 2'b10
  } rpt_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_SEND = 2'b10
  } tx_state_e;

  function automatic rpt_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b01:   decode_mode = MODE_SINGLE;
      2'b10:   decode_mode = MODE_AUTO;
      default: decode_mode = MODE_OFF;
    endcase
  endfunction

endpackage

// File: rtl/spg_rst_sync.sv
module spg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/spg_ctrl.sv
module spg_ctrl
  import status_pkt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [BYTE_W-1:0] wd,
  input  logic             clr_arm,
  output rpt_mode_e        mode_o,
  output logic [TAG_W-1:0] tag_o,
  output logic             armed_o
);
  rpt_mode_e        mode_q, mode_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             arm_q, arm_d;

  always_comb begin
    mode_d = mode_q;
    tag_d  = tag_q;
    arm_d  = arm_q;
    if (clr_arm) arm_d = 1'b0;
    if (we) begin
      mode_d = decode_mode(wd[BYTE_W-1 -: 2]);
      tag_d  = wd[TAG_W-1:0];
      arm_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      tag_q  <= '0;
      arm_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      tag_q  <= tag_d;
      arm_q  <= arm_d;
    end
  end

  assign mode_o  = mode_q;
  assign tag_o   = tag_q;
  assign armed_o = arm_q;

  // R6: a write lands the tag from the low six data bits on the next clock
  a_r6_tag_load: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (tag_q == $past(wd[TAG_W-1:0])));

  // R6: the 11 code behaves as off
  a_r6_code3_off: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wd[BYTE_W-1 -: 2] == 2'b11) |=> (mode_q == MODE_OFF));
endmodule

// File: rtl/spg_change.sv
module spg_change #(
  parameter int unsigned WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] status,
  input  logic             capture,
  output logic             differs
);
  logic [WIDTH-1:0] last_q, last_d;

  always_comb begin
    last_d = last_q;
    if (capture) last_d = status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= last_d;
  end

  assign differs = (status != last_q);

  // R9: a capture with status held leaves no pending difference
  a_r9_capture_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && $stable(status)) |=> (last_q == $past(status)));
endmodule

// File: rtl/spg_sequencer.sv
module spg_sequencer
  import status_pkt_pkg::*;
#(
  parameter int unsigned WIDTH = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [WIDTH-1:0]  status,
  input  logic [TAG_W-1:0]  tag,
  input  logic              start,
  output logic              latch_o,
  output logic              rq,
  output logic [BYTE_W-1:0] ad
);
  localparam int unsigned NB    = (WIDTH - LOW_W + BYTE_W - 1) / BYTE_W;
  localparam int unsigned PAD_W = LOW_W + BYTE_W * NB;
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

  tx_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [WIDTH-1:0] snap_q, snap_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             latch;

  logic [PAD_W-1:0]  padded;
  logic [BYTE_W-1:0] pay_bytes [NB];

  assign padded = PAD_W'(snap_q);

  for (genvar i = 0; i < NB; i++) begin : g_slice
    assign pay_bytes[i] = padded[LOW_W + BYTE_W*i +: BYTE_W];
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    latch   = 1'b0;
    case (state_q)
      ST_IDLE: if (go) begin
        latch   = 1'b1;
        state_d = ST_REQ;
      end
      ST_REQ: if (start) begin
        state_d = ST_SEND;
        idx_d   = '0;
      end
      ST_SEND: begin
        if (idx_q == LAST_IDX) state_d = ST_IDLE;
        else                   idx_d   = idx_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    snap_d = snap_q;
    tag_d  = tag_q;
    if (latch) begin
      snap_d = status;
      tag_d  = tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      snap_q  <= '0;
      tag_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      snap_q  <= snap_d;
      tag_q   <= tag_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_REQ:  ad = {tag_q, snap_q[LOW_W-1:0]};
      ST_SEND: ad = pay_bytes[idx_q];
      default: ad = '0;
    endcase
  end

  assign rq      = (state_q == ST_REQ);
  assign latch_o = latch;

  a_r3_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rq && !start) |=> rq);

  a_r3_drop_req: assert property (@(posedge clk) disable iff (!rst_n)
    (rq && start) |=> !rq);

  a_r10_header_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (rq && !start) |=> $stable(ad));

  a_r5_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (ad == '0));
endmodule

// File: rtl/status_pkt_gen.sv
module status_pkt_gen
  import status_pkt_pkg::*;
#(
  parameter int unsigned PAYLOAD_BITS = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [7:0]              wd,
  input  logic [PAYLOAD_BITS-1:0] status,
  input  logic                    start,
  output logic                    rq,
  output logic [7:0]              ad
);
  logic             srst_n;
  rpt_mode_e        mode;
  logic [TAG_W-1:0] tag;
  logic             armed;
  logic             differs;
  logic             latch;
  logic             go;

  spg_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  spg_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .we      (we),
    .wd      (wd),
    .clr_arm (latch),
    .mode_o  (mode),
    .tag_o   (tag),
    .armed_o (armed)
  );

  spg_change #(.WIDTH(PAYLOAD_BITS)) u_change (
    .clk     (clk),
    .rst_n   (srst_n),
    .status  (status),
    .capture (latch),
    .differs (differs)
  );

  always_comb begin
    case (mode)
      MODE_SINGLE: go = armed;
      MODE_AUTO:   go = armed || differs;
      default:     go = 1'b0;
    endcase
  end

  spg_sequencer #(.WIDTH(PAYLOAD_BITS)) u_seq (
    .clk     (clk),
    .rst_n   (srst_n),
    .go      (go),
    .status  (status),
    .tag     (tag),
    .start   (start),
    .latch_o (latch),
    .rq      (rq),
    .ad      (ad)
  );

  // R7: a request only ever rises out of single or auto mode
  a_r7_off_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(rq) |-> ($past(mode) != MODE_OFF));

  initial begin
    a_r5_width_range: assert (PAYLOAD_BITS >= 3 && PAYLOAD_BITS <= MAX_BITS);
  end
endmodule

// File: tb/status_pkt_gen_test.sv
`timescale 1ns/1ps
module status_pkt_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  wd = '0;
  logic [25:0] st = '0;
  logic        start = 1'b0;

  logic       rq7, rq15, rq26;
  logic [7:0] ad7, ad15, ad26;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  localparam int W [3] = '{7, 15, 26};
  localparam int NB[3] = '{1, 2, 3};

  logic [7:0] expq [3][$];
  int  pay   [3] = '{0, 0, 0};
  int  npkt  [3] = '{0, 0, 0};
  bit  was_rq[3] = '{0, 0, 0};
  int  exp_pk = 0;

  always #4 clk = ~clk;

  status_pkt_gen #(.PAYLOAD_BITS(7)) uut_w7 (
    .clk(clk), .rst_n(rst_n), .we(we), .wd(wd), .status(st[6:0]),
    .start(start), .rq(rq7), .ad(ad7));
  status_pkt_gen #(.PAYLOAD_BITS(15)) uut (
    .clk(clk), .rst_n(rst_n), .we(we), .wd(wd), .status(st[14:0]),
    .start(start), .rq(rq15), .ad(ad15));
  status_pkt_gen #(.PAYLOAD_BITS(26)) uut_w26 (
    .clk(clk), .rst_n(rst_n), .we(we), .wd(wd), .status(st),
    .start(start), .rq(rq26), .ad(ad26));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] pay_byte(input logic [25:0] s, input int w,
                                          input int i);
    logic [25:0] m;
    m = s & ((26'd1 << w) - 26'd1);
    return 8'((m >> (2 + 8*i)) & 26'hFF);
  endfunction

  // driver side of the scoreboard: push the bytes a packet must carry
  task automatic expect_pkt(input logic [5:0] tag, input logic [25:0] s);
    for (int k = 0; k < 3; k++) begin
      expq[k].push_back({tag, s[1:0]});
      for (int i = 0; i < NB[k]; i++) expq[k].push_back(pay_byte(s, W[k], i));
    end
    exp_pk++;
  endtask

  // monitor side
  task automatic mon(input int k, input logic r, input logic [7:0] a);
    logic [7:0] e;
    if (r) begin
      if (!was_rq[k]) npkt[k]++;
      if (expq[k].size() == 0) begin
        chk(1'b0, "R2 unexpected request", {24'd0, a}, 32'd0);
      end else begin
        e = expq[k][0];
        chk(a == e, "R2 header byte", {24'd0, a}, {24'd0, e});
        if (start) begin
          void'(expq[k].pop_front());
          pay[k] = NB[k];
        end
      end
    end else if (pay[k] > 0) begin
      if (expq[k].size() == 0) begin
        chk(1'b0, "R4 payload without expectation", {24'd0, a}, 32'd0);
      end else begin
        e = expq[k].pop_front();
        chk(a == e, "R4 R5 payload byte", {24'd0, a}, {24'd0, e});
      end
      pay[k]--;
    end else begin
      chk(a == 8'd0, "R11 quiet bus", {24'd0, a}, 32'd0);
    end
    was_rq[k] = r;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      mon(0, rq7, ad7);
      mon(1, rq15, ad15);
      mon(2, rq26, ad26);
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic ctl_write(input logic [1:0] m, input logic [5:0] tag);
    we = 1'b1;
    wd = {m, tag};
    tick();
    we = 1'b0;
  endtask

  task automatic wait_rq();
    bit seen = 0;
    for (int c = 0; c < 20 && !seen; c++) begin
      @(negedge clk);
      seen = rq15;
    end
    chk(seen, "R3 request expected", {31'd0, seen}, 32'd1);
  endtask

  task automatic ack();
    tick();
    start = 1'b1;
    tick();
    start = 1'b0;
    @(negedge clk);
    chk(!rq15 && !rq7 && !rq26, "R3 request drops after ack",
        {29'd0, rq7, rq15, rq26}, 32'd0);
  endtask

  task automatic count_chk(input string req);
    for (int k = 0; k < 3; k++)
      chk(npkt[k] == exp_pk, req, npkt[k], exp_pk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(rq15 == 1'b0 && ad15 == 8'd0, "R1 reset outputs", {23'd0, rq15, ad15}, 32'd0);
    rst_n = 1'b1;
    repeat (6) tick();
    chk(rq15 == 1'b0 && ad15 == 8'd0, "R1 after release", {23'd0, rq15, ad15}, 32'd0);

    // R8, R10: single shot, status changed while the request waits
    st = 26'h2A5_C3B6;
    expect_pkt(6'h2A, 26'h2A5_C3B6);
    ctl_write(2'b01, 6'h2A);
    wait_rq();
    repeat (3) tick();
    @(negedge clk);
    chk(rq15, "R3 request held without ack", {31'd0, rq15}, 32'd1);
    st = 26'h155_3C49; // R10: must not reach the packet in flight
    ack();
    repeat (20) tick();
    count_chk("R8 one packet per single write");

    // R7: off mode ignores status changes
    ctl_write(2'b00, 6'h11);
    st = 26'h0F0_F0F2;
    repeat (20) tick();
    count_chk("R7 no packet in off mode");

    // R9: auto mode entry, quiet while unchanged, then a change
    st = 26'h3C3_A5A1;
    expect_pkt(6'h05, 26'h3C3_A5A1);
    ctl_write(2'b10, 6'h05);
    wait_rq();
    ack();
    repeat (15) tick();
    count_chk("R9 no packet while status unchanged");

    st = 26'h012_3456;
    expect_pkt(6'h05, 26'h012_3456);
    wait_rq();
    tick();
    st = 26'h3ED_CBA7; // R10 and R9: second packet follows the first
    expect_pkt(6'h05, 26'h3ED_CBA7);
    repeat (2) tick();
    ack();
    wait_rq();
    ack();
    repeat (15) tick();
    count_chk("R9 change during request gives a second packet");

    // R6: code 11 selects off
    ctl_write(2'b11, 6'h22);
    st = 26'h111_1110;
    repeat (20) tick();
    count_chk("R6 code 11 acts as off");

    // R4 R5 R6: full tag and all-ones status, zero padded top slices
    st = 26'h3FF_FFFF;
    expect_pkt(6'h3F, 26'h3FF_FFFF);
    ctl_write(2'b01, 6'h3F);
    wait_rq();
    ack();
    repeat (10) tick();
    count_chk("R8 boundary packet count");
    for (int k = 0; k < 3; k++)
      chk(expq[k].size() == 0, "R4 all expected bytes seen", expq[k].size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule